// File: doc/BRIEF.md
# Pulse Accumulator with Interrupt Flags

This block counts edges on an external input pin and reports them through status flags. The pin passes through a synchronizer. A small state machine then tracks the settled level of the pin and produces one pulse for each edge of the chosen polarity. Each pulse advances an 8-bit count and sets an edge flag. When the count passes from its highest value back to zero, an overflow flag is also set. Software can read and rewrite the count over a byte-wide register bus.

Two further timer events share the same mask and flag registers: a timer-overflow flag and a periodic-tick flag. Each is set by a one-cycle pulse input. Every flag has its own enable. A flag is set and cleared independently of its enable, so the same logic works for both polled and interrupt-driven software. A flag is cleared by writing a one to its bit position. The accumulator requests and the timer requests come out on separate interrupt lines.

The edge state machine has two states. `LVL_LOW` means the settled pin is 0, and `LVL_HIGH` means it is 1. The transition `LVL_LOW -> LVL_HIGH` (rise) is taken when the synchronized level reads 1. The transition `LVL_HIGH -> LVL_LOW` (fall) is taken when it reads 0. An edge pulse is produced on the rise transition when `rise_sel` is 1, and on the fall transition when `rise_sel` is 0.

Top module: `pacc_top`

## Requirements
- R1: After reset the count, mask and flag registers read 0x00, `prescale` is 0 and both interrupt outputs are low.
- R2: With `rise_sel`=1 each rising edge of `pin_in` adds one to the count, and falling edges leave it unchanged. The count changes on the third clock edge after the pin changes.
- R3: With `rise_sel`=0 each falling edge of `pin_in` adds one to the count, and rising edges leave it unchanged.
- R4: The count wraps from 0xFF to 0x00, and that wrap sets the accumulator overflow flag, which is bit 5 of the flag register.
- R5: Every counted edge sets the accumulator edge flag, which is bit 4 of the flag register.
- R6: Writing the flag register clears each flag whose bit (7, 6, 5 or 4) is written as 1, and leaves each flag whose bit is written as 0 unchanged.
- R7: When a flag's set event and a one-to-clear write to that flag fall in the same cycle, the flag ends up set.
- R8: Enables never alter flags. `pacc_irq` = (flag bit 5 AND mask bit 5) OR (flag bit 4 AND mask bit 4).
- R9: `tov_pulse` sets flag bit 7 and `rti_pulse` sets flag bit 6. `timer_irq` = (flag bit 7 AND mask bit 7) OR (flag bit 6 AND mask bit 6).
- R10: In the mask register, bits 7:4 are the enables, bits 3:2 read as 0, and bits 1:0 are the prescaler select driven on `prescale`. Flag register bits 3:0 read as 0.
- R11: A bus write to the count in the same cycle as a counted edge stores the written value, and the increment is dropped.
- R12: The mask register is at address 0x24, the flag register at 0x25 and the count at 0x27. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| rise_sel | input | 1 | 1 counts rising edges, 0 counts falling edges |
| tov_pulse | input | 1 | One-cycle timer-overflow event |
| rti_pulse | input | 1 | One-cycle periodic-tick event |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| prescale | output | 2 | Prescaler select from mask bits 1:0 |
| pacc_irq | output | 1 | Accumulator interrupt request |
| timer_irq | output | 1 | Timer-overflow / periodic-tick interrupt request |

## Verification
The assertions check, on every cycle, the following rules:
- A write to the count takes priority over an increment.
- The count steps by one or wraps to zero.
- A set event always leaves its flag set.
- A flag holds its value unless it is set or cleared.
- The accumulator request never rises without a flag.
- No edge pulse occurs twice for one transition.

The bench scenarios cover what a per-cycle property cannot show:
- The three-cycle pin-to-count latency.
- Edges of the unselected polarity being ignored.
- The exact wrap point.
- The full sweep of 256 mask values against the interrupt outputs.
- All 16 one-to-clear patterns.
- The same-cycle collisions observed at the ports.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 8'h24;
    localparam logic [ADDR_W-1:0] ADDR_FLAG  = 8'h25;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 8'h27;
    // Index into the 4-bit flag/enable vectors (vector bit n sits at register bit n+4)
    localparam int IX_TOV  = 3;
    localparam int IX_RTI  = 2;
    localparam int IX_POVF = 1;
    localparam int IX_PEDG = 0;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;
endpackage

// File: rtl/pacc_edge_fsm.sv
module pacc_edge_fsm #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic rise_sel,
    output logic edge_hit
);
    import pacc_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    lvl_state_t             state_q, state_d;

    // Synchronizer chain, one flop per stage
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sync_q[g] <= 1'b0;
                else
                    sync_q[g] <= (g == 0) ? pin_in : sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LVL_LOW;
        else
            state_q <= state_d;
    end

    // Next state and edge output
    always_comb begin
        state_d  = state_q;
        edge_hit = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (level) begin
                    state_d  = LVL_HIGH;
                    edge_hit = rise_sel;
                end
            end
            LVL_HIGH: begin
                if (!level) begin
                    state_d  = LVL_LOW;
                    edge_hit = !rise_sel;
                end
            end
        endcase
    end

    // R2 / R3: one pulse per transition while the selection is steady
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (!edge_hit || (rise_sel != $past(rise_sel))));
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (wr_en)
            count_q <= wdata;
        else if (inc)
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;
    assign wrap  = inc && !wr_en && (count_q == CNT_MAX);

    // R11: a bus write always wins
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wdata));
    // R4: rollover to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en && count == CNT_MAX) |=> count == '0);
    // R2: plain step of one
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en && count != CNT_MAX) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] set_vec,
    input  logic       wr_mask,
    input  logic [5:0] mask_wdata,
    input  logic       wr_flag,
    input  logic [3:0] clr_vec,
    output logic [3:0] enables,
    output logic [1:0] presc,
    output logic [3:0] flags,
    output logic       pacc_irq,
    output logic       timer_irq
);
    import pacc_pkg::*;

    logic [3:0] en_q, flag_q, clr_eff;
    logic [1:0] presc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            presc_q <= '0;
        end else if (wr_mask) begin
            en_q    <= mask_wdata[5:2];
            presc_q <= mask_wdata[1:0];
        end
    end

    assign clr_eff = wr_flag ? clr_vec : 4'b0000;

    // Set has priority over clear so no event is lost
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~clr_eff) | set_vec;
    end

    always_comb begin
        pacc_irq  = (flag_q[IX_POVF] & en_q[IX_POVF]) | (flag_q[IX_PEDG] & en_q[IX_PEDG]);
        timer_irq = (flag_q[IX_TOV]  & en_q[IX_TOV])  | (flag_q[IX_RTI]  & en_q[IX_RTI]);
    end

    assign enables = en_q;
    assign presc   = presc_q;
    assign flags   = flag_q;

    // R7: every set event lands
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != 4'b0000) |=> ((flags & $past(set_vec)) == $past(set_vec)));
    // R6: untouched flags hold, mask writes included
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag && set_vec == 4'b0000) |=> $stable(flags));
    // R6: cleared bits drop when nothing sets them
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && set_vec == 4'b0000) |=> ((flags & $past(clr_vec)) == 4'b0000));
    // R8: the accumulator request needs an accumulator flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pacc_irq |-> (flags[IX_POVF] | flags[IX_PEDG]));
endmodule

// File: rtl/pacc_top.sv
module pacc_top #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pin_in,
    input  logic                          rise_sel,
    input  logic                          tov_pulse,
    input  logic                          rti_pulse,
    input  logic [pacc_pkg::ADDR_W-1:0]   bus_addr,
    input  logic                          bus_wr,
    input  logic [pacc_pkg::DATA_W-1:0]   bus_wdata,
    output logic [pacc_pkg::DATA_W-1:0]   bus_rdata,
    output logic [1:0]                    prescale,
    output logic                          pacc_irq,
    output logic                          timer_irq
);
    import pacc_pkg::*;

    logic              edge_hit, wrap;
    logic [DATA_W-1:0] count;
    logic [3:0]        enables, flags, set_vec;
    logic              wr_mask, wr_flag, wr_count;

    assign wr_mask  = bus_wr && (bus_addr == ADDR_MASK);
    assign wr_flag  = bus_wr && (bus_addr == ADDR_FLAG);
    assign wr_count = bus_wr && (bus_addr == ADDR_COUNT);

    pacc_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .rise_sel (rise_sel),
        .edge_hit (edge_hit)
    );

    pacc_counter #(.W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (edge_hit),
        .wr_en (wr_count),
        .wdata (bus_wdata),
        .count (count),
        .wrap  (wrap)
    );

    assign set_vec = {tov_pulse, rti_pulse, wrap, edge_hit};

    pacc_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .wr_mask    (wr_mask),
        .mask_wdata ({bus_wdata[7:4], bus_wdata[1:0]}),
        .wr_flag    (wr_flag),
        .clr_vec    (bus_wdata[7:4]),
        .enables    (enables),
        .presc      (prescale),
        .flags      (flags),
        .pacc_irq   (pacc_irq),
        .timer_irq  (timer_irq)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_MASK:  bus_rdata = {enables, 2'b00, prescale};
            ADDR_FLAG:  bus_rdata = {flags, 4'b0000};
            ADDR_COUNT: bus_rdata = count;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/pacc_top_test.sv
`timescale 1ns/1ps
module pacc_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0, rise_sel = 1'b1, tov_pulse = 1'b0, rti_pulse = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] prescale;
    logic       pacc_irq, timer_irq;
    int         total = 0, failed = 0;
    bit         done = 1'b0;
    logic [7:0] rv;

    pacc_top uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pin_to(input logic v);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input bit tov, input bit rti);
        tov_pulse = tov; rti_pulse = rti;
        @(negedge clk);
        tov_pulse = 1'b0; rti_pulse = 1'b0;
    endtask

    task automatic set_all_flags;
        rise_sel = 1'b1;
        wr(8'h27, 8'hFF);
        pin_to(1'b1);
        pin_to(1'b0);
        pulse(1'b1, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h24, rv); chk("R1 mask", rv, 8'h00);
        rd(8'h25, rv); chk("R1 flag", rv, 8'h00);
        rd(8'h27, rv); chk("R1 count", rv, 8'h00);
        chk("R1 outputs", {4'b0, prescale, pacc_irq, timer_irq}, 8'h00);
        // R12 unused address
        rd(8'h26, rv); chk("R12 unused addr", rv, 8'h00);

        // R2/R3/R4/R5 edge sweep for both polarities
        for (int s = 1; s >= 0; s--) begin
            rise_sel = s[0];
            wr(8'h25, 8'hF0);
            wr(8'h27, 8'hFC);
            for (int k = 1; k <= 6; k++) begin
                logic [7:0] exp_cnt;
                exp_cnt = 8'(8'hFC + k);
                if (s == 1) begin
                    pin_to(1'b1);
                    rd(8'h27, rv); chk("R2 rising counted", rv, exp_cnt);
                    pin_to(1'b0);
                    rd(8'h27, rv); chk("R2 falling ignored", rv, exp_cnt);
                end else begin
                    pin_to(1'b1);
                    rd(8'h27, rv); chk("R3 rising ignored", rv, 8'(exp_cnt - 1));
                    pin_to(1'b0);
                    rd(8'h27, rv); chk("R3 falling counted", rv, exp_cnt);
                end
                rd(8'h25, rv);
                chk("R4 R5 flags", rv, (k >= 4) ? 8'h30 : 8'h10);
            end
        end

        // R2 latency: count moves on the third edge after the pin change
        rise_sel = 1'b1;
        wr(8'h27, 8'h20);
        pin_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(8'h27, rv); chk("R2 not yet", rv, 8'h20);
        @(negedge clk);
        rd(8'h27, rv); chk("R2 third edge", rv, 8'h21);
        pin_to(1'b0);

        // R11 write vs increment collision
        wr(8'h25, 8'hF0);
        wr(8'h27, 8'h10);
        pin_in = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(8'h27, 8'h40);
        repeat (2) @(negedge clk);
        rd(8'h27, rv); chk("R11 write wins", rv, 8'h40);
        rd(8'h25, rv); chk("R5 edge flag on collision", rv, 8'h10);
        pin_to(1'b0);

        // R9 timer pulses
        wr(8'h25, 8'hF0);
        pulse(1'b1, 1'b0);
        rd(8'h25, rv); chk("R9 tov sets bit7", rv, 8'h80);
        pulse(1'b0, 1'b1);
        rd(8'h25, rv); chk("R9 rti sets bit6", rv, 8'hC0);

        // R7 set beats clear in the same cycle
        wr(8'h25, 8'hF0);
        tov_pulse = 1'b1; rti_pulse = 1'b1;
        wr(8'h25, 8'hC0);
        tov_pulse = 1'b0; rti_pulse = 1'b0;
        rd(8'h25, rv); chk("R7 set wins", rv, 8'hC0);

        // R8/R9/R10 full mask sweep with all flags set
        set_all_flags();
        rd(8'h25, rv); chk("R4 R5 R9 all flags", rv, 8'hF0);
        for (int v = 0; v < 256; v++) begin
            wr(8'h24, 8'(v));
            rd(8'h24, rv); chk("R10 mask readback", rv, 8'(v) & 8'hF3);
            chk("R10 prescale", {6'b0, prescale}, 8'(v & 3));
            chk("R8 pacc_irq", {7'b0, pacc_irq}, {7'b0, v[5] | v[4]});
            chk("R9 timer_irq", {7'b0, timer_irq}, {7'b0, v[7] | v[6]});
            rd(8'h25, rv); chk("R8 enables keep flags", rv, 8'hF0);
        end

        // R8 single-flag gating
        wr(8'h24, 8'h20);
        wr(8'h25, 8'hD0);
        chk("R8 ovf only irq", {7'b0, pacc_irq}, 8'h01);
        wr(8'h25, 8'h20);
        chk("R8 no flag no irq", {7'b0, pacc_irq}, 8'h00);

        // R6 all clear patterns
        for (int p = 0; p < 16; p++) begin
            set_all_flags();
            wr(8'h25, {4'(p), 4'hF});
            rd(8'h25, rv); chk("R6 one-to-clear", rv, {~4'(p), 4'h0});
        end

        // R12 writes to an unused address touch nothing
        set_all_flags();
        wr(8'h27, 8'h55);
        wr(8'h26, 8'hFF);
        rd(8'h27, rv); chk("R12 count untouched", rv, 8'h55);
        rd(8'h25, rv); chk("R12 flags untouched", rv, 8'hF0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule